// File: doc/BRIEF.md
# Serially Programmed Frequency Divider

This block divides an incoming frequency by a programmable ratio N. The ratio is loaded over a three-wire serial port (serial clock, data, enable) that runs asynchronously to the system clock. Each incoming frequency cycle reaches the block as a one-cycle `fin_tick` strobe. After every N strobes the block emits a single-cycle `div_pulse`, which is meant to feed a phase comparator.

The serial pins pass through synchronizers. Each rising edge of the serial clock shifts one data bit into a 14-bit shadow register, most significant bit first. A rising edge on enable hands the shadow contents to a small load controller with three states. `ST_SHIFT` accepts bits. On the enable rising edge it moves to `ST_CHECK`, which lasts one cycle. In that cycle the shadow value is compared with the minimum ratio. A legal value becomes the pending ratio. A value below the minimum raises `ratio_err` for one cycle and leaves the ratio unchanged. `ST_CHECK` always moves on to `ST_ARMED`. That state ignores serial bits and returns to `ST_SHIFT` once enable reads low again.

The down-counter reloads from the pending ratio only when it reaches terminal count. A new ratio therefore never cuts short the period already in progress.

Top module: `serial_ratio_divider`

## Requirements
- R1: A synchronous reset sets the ratio to 5, clears the counter and drives both outputs low. The first `fin_tick` after reset produces a pulse.
- R2: `div_pulse` is high for exactly one clock cycle, namely the cycle after the `fin_tick` strobe that finds the counter at terminal count. With ratio N there is one pulse for every N strobes.
- R3: Serial data is sampled on rising edges of `ser_clk` and enters most significant bit first. When more than 14 bits are clocked in, only the last 14 count.
- R4: A rising edge on `ser_en` transfers the shadow value into the pending ratio, provided the value is at least 5.
- R5: A transferred value below 5 (0 to 4) is rejected. The previous ratio stays in force, and `ratio_err` is high for exactly one cycle.
- R6: A newly accepted ratio takes effect only at the next terminal count, so the period in progress finishes at the old ratio.
- R7: Every ratio from 5 up to the maximum 16383 divides correctly.
- R8: `ser_clk` edges that occur while `ser_en` is high leave the shadow register unchanged. A later enable edge transfers the same value again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| ser_clk | input | 1 | Serial clock; data is sampled on its rising edge |
| ser_data | input | 1 | Serial ratio data, MSB first |
| ser_en | input | 1 | Transfer strobe; rising edge loads the shadow value |
| fin_tick | input | 1 | One-cycle strobe per input frequency cycle |
| div_pulse | output | 1 | One-cycle pulse every N input strobes |
| ratio_err | output | 1 | One-cycle pulse when a loaded value is below 5 |

## Verification
The bench builds the block with its default parameters: a 14-bit ratio, a minimum and reset ratio of 5, and two synchronizer stages. With these values the full legal range is within reach, including the 16383 maximum, which is run through two complete periods. Both rejection boundaries are exercised, 4 rejected and 5 accepted. The 14-bit width also makes the truncation of over-long serial words and the suppression of bits clocked during enable observable in the output period.

// File: rtl/sdiv_pkg.sv
package sdiv_pkg;
    typedef enum logic [1:0] {
        ST_SHIFT = 2'd0,
        ST_CHECK = 2'd1,
        ST_ARMED = 2'd2
    } ld_state_e;
endpackage

// File: rtl/sdiv_sync_edge.sv
module sdiv_sync_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d_async,
    output logic level,
    output logic rise
);
    logic [STAGES:0] pipe;

    always_ff @(posedge clk) begin
        if (rst) pipe <= '0;
        else     pipe <= {pipe[STAGES-1:0], d_async};
    end

    assign level = pipe[STAGES-1];
    assign rise  = pipe[STAGES-1] & ~pipe[STAGES];
endmodule

// File: rtl/sdiv_ratio_ctrl.sv
module sdiv_ratio_ctrl
    import sdiv_pkg::*;
#(
    parameter int WIDTH       = 14,
    parameter int MIN_RATIO   = 5,
    parameter int RESET_RATIO = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             bit_stb,
    input  logic             bit_val,
    input  logic             en_lvl,
    input  logic             en_rise,
    output logic [WIDTH-1:0] ratio,
    output logic             err
);
    localparam logic [WIDTH-1:0] MIN_V = WIDTH'(MIN_RATIO);
    localparam logic [WIDTH-1:0] RST_V = WIDTH'(RESET_RATIO);

    ld_state_e        state, nxt;
    logic [WIDTH-1:0] shadow;

    always_ff @(posedge clk) begin
        if (rst) state <= ST_SHIFT;
        else     state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            ST_SHIFT: if (en_rise) nxt = ST_CHECK;
            ST_CHECK: nxt = ST_ARMED;
            ST_ARMED: if (!en_lvl) nxt = ST_SHIFT;
            default:  nxt = ST_SHIFT;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            shadow <= '0;
            ratio  <= RST_V;
            err    <= 1'b0;
        end else begin
            err <= 1'b0;
            unique case (state)
                ST_SHIFT: if (bit_stb && !en_lvl) shadow <= {shadow[WIDTH-2:0], bit_val};
                ST_CHECK: begin
                    if (shadow < MIN_V) err   <= 1'b1;
                    else                ratio <= shadow;
                end
                ST_ARMED: ;
                default:  ;
            endcase
        end
    end

    p_ratio_floor_r5: assert property (@(posedge clk) disable iff (rst)
        ratio >= MIN_V);
    p_err_single_r5: assert property (@(posedge clk) disable iff (rst)
        err |=> !err);
    p_ratio_only_on_check_r4: assert property (@(posedge clk) disable iff (rst)
        (state != ST_CHECK) |=> $stable(ratio));
    p_armed_freeze_r8: assert property (@(posedge clk) disable iff (rst)
        (state == ST_ARMED) |=> $stable(shadow));
endmodule

// File: rtl/sdiv_counter.sv
module sdiv_counter #(
    parameter int WIDTH = 14
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic [WIDTH-1:0] ratio,
    output logic             pulse
);
    logic [WIDTH-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt   <= '0;
            pulse <= 1'b0;
        end else begin
            pulse <= 1'b0;
            if (tick) begin
                if (cnt == '0) begin
                    pulse <= 1'b1;
                    cnt   <= ratio - 1'b1;
                end else begin
                    cnt <= cnt - 1'b1;
                end
            end
        end
    end

    p_pulse_after_tick_r2: assert property (@(posedge clk) disable iff (rst)
        pulse |-> $past(tick));
    p_pulse_single_r2: assert property (@(posedge clk) disable iff (rst)
        pulse |=> !pulse);
    p_idle_hold_r6: assert property (@(posedge clk) disable iff (rst)
        !tick |=> $stable(cnt));
endmodule

// File: rtl/serial_ratio_divider.sv
module serial_ratio_divider #(
    parameter int WIDTH       = 14,
    parameter int MIN_RATIO   = 5,
    parameter int RESET_RATIO = 5,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic ser_clk,
    input  logic ser_data,
    input  logic ser_en,
    input  logic fin_tick,
    output logic div_pulse,
    output logic ratio_err
);
    logic sclk_lvl, sclk_rise;
    logic sdat_lvl, sdat_rise;
    logic sen_lvl, sen_rise;
    logic [WIDTH-1:0] ratio_w;

    sdiv_sync_edge #(.STAGES(SYNC_STAGES)) u_sync_clk (
        .clk(clk), .rst(rst), .d_async(ser_clk), .level(sclk_lvl), .rise(sclk_rise));
    sdiv_sync_edge #(.STAGES(SYNC_STAGES)) u_sync_dat (
        .clk(clk), .rst(rst), .d_async(ser_data), .level(sdat_lvl), .rise(sdat_rise));
    sdiv_sync_edge #(.STAGES(SYNC_STAGES)) u_sync_en (
        .clk(clk), .rst(rst), .d_async(ser_en), .level(sen_lvl), .rise(sen_rise));

    sdiv_ratio_ctrl #(
        .WIDTH(WIDTH), .MIN_RATIO(MIN_RATIO), .RESET_RATIO(RESET_RATIO)
    ) u_ctrl (
        .clk(clk), .rst(rst), .bit_stb(sclk_rise), .bit_val(sdat_lvl),
        .en_lvl(sen_lvl), .en_rise(sen_rise), .ratio(ratio_w), .err(ratio_err));

    sdiv_counter #(.WIDTH(WIDTH)) u_cnt (
        .clk(clk), .rst(rst), .tick(fin_tick), .ratio(ratio_w), .pulse(div_pulse));

    logic unused_ok;
    assign unused_ok = sclk_lvl ^ sdat_rise;

    p_outputs_quiet_r1: assert property (@(posedge clk)
        $past(rst) |-> (!div_pulse && !ratio_err));
endmodule

// File: tb/serial_ratio_divider_tb_top.sv
module serial_ratio_divider_tb_top;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic ser_clk = 1'b0, ser_data = 1'b0, ser_en = 1'b0, fin_tick = 1'b0;
    logic div_pulse, ratio_err;

    int checks = 0, fails = 0;
    int mpend = 5, mrem = 0;
    bit exp_p = 1'b0;
    bit in_write = 1'b0;
    int err_cnt = 0;
    string tag = "R1";

    always #4 clk = ~clk;

    serial_ratio_divider dut_i (
        .clk(clk), .rst(rst), .ser_clk(ser_clk), .ser_data(ser_data),
        .ser_en(ser_en), .fin_tick(fin_tick), .div_pulse(div_pulse), .ratio_err(ratio_err));

    // Behavioural model: remaining strobes until the next pulse
    always @(posedge clk) begin
        if (rst) begin
            mrem  = 0;
            exp_p = 1'b0;
        end else begin
            exp_p = 1'b0;
            if (fin_tick) begin
                if (mrem == 0) begin
                    exp_p = 1'b1;
                    mrem  = mpend - 1;
                end else begin
                    mrem = mrem - 1;
                end
            end
        end
    end

    always @(negedge clk) begin
        if (!rst) begin
            checks++;
            if (div_pulse !== exp_p) begin
                fails++;
                $display("FAIL %s: div_pulse got %0b expected %0b at %0t", tag, div_pulse, exp_p, $time);
            end
            if (ratio_err) err_cnt++;
            if (ratio_err && !in_write) begin
                checks++; fails++;
                $display("FAIL R5: ratio_err got 1 expected 0 outside a load at %0t", $time);
            end
        end
    end

    task automatic check(string t, int got, int exp);
        checks++;
        if (got != exp) begin
            fails++;
            $display("FAIL %s: got %0d expected %0d", t, got, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        mpend = 5;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        check("R1 reset div_pulse", div_pulse, 0);
        check("R1 reset ratio_err", ratio_err, 0);
    endtask

    task automatic shift_bits(logic [31:0] v, int n);
        @(negedge clk);
        for (int i = n - 1; i >= 0; i--) begin
            ser_data = v[i];
            #304 ser_clk = 1'b1;
            #304 ser_clk = 1'b0;
            #304;
        end
    endtask

    task automatic en_pulse();
        #304 ser_en = 1'b1;
        #608 ser_en = 1'b0;
        #608;
        repeat (4) @(negedge clk);
    endtask

    task automatic load(logic [31:0] v, int n, int exp_err, int new_pend, string t);
        in_write = 1'b1;
        err_cnt = 0;
        shift_bits(v, n);
        en_pulse();
        check({t, " ratio_err pulses"}, err_cnt, exp_err);
        mpend = new_pend;
        in_write = 1'b0;
    endtask

    task automatic run_ticks(int n, int gap);
        for (int i = 0; i < n; i++) begin
            @(negedge clk) fin_tick = 1'b1;
            @(negedge clk) fin_tick = 1'b0;
            repeat (gap) @(negedge clk);
        end
    endtask

    initial begin
        #(190000 * 8);
        fails++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", checks, fails);
        $finish;
    end

    initial begin
        do_reset();
        tag = "R1"; run_ticks(12, 0);
        tag = "R2"; run_ticks(9, 3);
        // mid-count change: 7 takes effect at next terminal count
        run_ticks(2, 0);
        load(32'd7, 14, 0, 7, "R4");
        tag = "R6"; run_ticks(22, 2);
        // rejection keeps 7
        load(32'd3, 14, 1, 7, "R5 value 3");
        tag = "R5"; run_ticks(15, 1);
        load(32'd0, 14, 1, 7, "R5 value 0");
        load(32'd4, 14, 1, 7, "R5 value 4");
        run_ticks(15, 0);
        // over-long word: 16 bits, last 14 give 9
        load(32'h0000_C009, 16, 0, 9, "R3");
        tag = "R3"; run_ticks(28, 1);
        // bits during enable ignored
        in_write = 1'b1; err_cnt = 0;
        shift_bits(32'd6, 14);
        #304 ser_en = 1'b1;
        #608;
        for (int i = 0; i < 3; i++) begin
            ser_data = 1'b1;
            #304 ser_clk = 1'b1;
            #304 ser_clk = 1'b0;
        end
        #304 ser_en = 1'b0;
        #608;
        en_pulse();
        check("R8 ratio_err pulses", err_cnt, 0);
        mpend = 6; in_write = 1'b0;
        tag = "R8"; run_ticks(25, 0);
        // boundary 5 and maximum
        load(32'd5, 14, 0, 5, "R4 value 5");
        tag = "R4"; run_ticks(16, 0);
        load(32'd16383, 14, 0, 16383, "R7");
        tag = "R7"; run_ticks(16383 * 2 + 6, 0);
        // reset mid-run restores ratio 5
        do_reset();
        tag = "R1"; run_ticks(11, 1);
        repeat (4) @(negedge clk);
        $display("[TB] %0d tests run, %0d failed", checks, fails);
        $finish;
    end
endmodule